// File: doc/BRIEF.md
# Character LCD Nibble Write Sequencer

This block drives the write side of a parallel character-display bus that runs with a four-bit data path. The read/write pin of the panel is assumed to be held low. An upstream controller asks for a transfer with a one-cycle request that carries a byte, a register-select bit and a mode-switch flag. The sequencer then sends the byte as nibbles on the upper four data lines, upper nibble first. It frames each nibble with an address-setup interval, a high enable pulse and a low tail. When the last tail has elapsed, it raises a one-cycle completion pulse.

The three bus intervals are given in nanoseconds and converted to whole clock cycles from a real-valued clock-frequency parameter, rounding up. The mode-switch flag is for the instruction that moves the panel into four-bit operation: the panel only latches that switch correctly if the upper nibble is strobed twice before the lower one. Power-up waits, per-instruction execution delays and any host register access belong to the controller that issues the requests.

Top module: `lcd_nibble_writer`

## Requirements
- R1: While reset is held and after its release with no request, `lcdE`, `lcdRs`, `lcdDq` and `done` are all zero.
- R2: On an accepted request, `lcdRs` takes the value of `wrRs` (0 = instruction, 1 = character data) and holds it through the transfer. `lcdDq` and `lcdRs` do not change while `lcdE` is high.
- R3: Before every rise of `lcdE`, `lcdDq` and `lcdRs` are stable with `lcdE` low for at least ceil(T_SETUP_NS × CLK_FREQ_HZ / 1e9) cycles, which is 5 cycles at the defaults.
- R4: Each high pulse of `lcdE` lasts at least ceil(T_PULSE_NS × f / 1e9) cycles, which is 32 cycles at the defaults.
- R5: Successive rises of `lcdE`, including those between nibbles of one byte, are at least ceil(T_CYCLE_NS × f / 1e9) cycles apart, which is 63 cycles at the defaults.
- R6: Without the mode-switch flag, a transfer gives exactly two enable strobes. The first carries byte bits 7:4 on `lcdDq[7:4]` and the second carries bits 3:0. `lcdDq[3:0]` is always zero.
- R7: With `wrFnSet` high on the request, a transfer gives exactly three strobes carrying bits 7:4, then bits 7:4 again, then bits 3:0.
- R8: `done` is high for exactly one cycle per transfer. It starts once the final strobe's low tail of ceil(T_CYCLE_NS × f / 1e9) − ceil(T_PULSE_NS × f / 1e9) cycles (31 at the defaults) has elapsed, and `lcdE` is low while it is high. A new request can be accepted in the `done` cycle.
- R9: A `wrEn` pulse that arrives while a transfer is in progress is ignored: it starts no transfer and does not change the byte, RS or strobe count of the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | One-cycle transfer request |
| wrByte | input | 8 | Byte to send |
| wrRs | input | 1 | Register select: 0 instruction, 1 data |
| wrFnSet | input | 1 | Send the upper nibble twice (mode-switch instruction) |
| done | output | 1 | One-cycle pulse when the transfer has finished |
| lcdE | output | 1 | Panel enable strobe |
| lcdRs | output | 1 | Panel register select |
| lcdDq | output | 8 | Panel data lines; nibble on 7:4, 3:0 held low |

## Verification
The assertions check the bus timing on every cycle: the setup run before each enable rise, the width of each high pulse, the spacing between rises, data and RS holding still while the enable is high, and the completion pulse being a single cycle with the enable low. Which nibble appears in which strobe, how many strobes a transfer has, the exact cycle of the completion pulse, and the rejection of requests made during a transfer can only be shown by the bench scenarios. Those scenarios use a cycle-by-cycle reference model run with normal, mode-switch, back-to-back and interrupted requests.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

  // Strobes from the sequencing control to the bus datapath.
  typedef struct packed {
    logic capture;   // take the request and present its upper nibble
    logic loadHigh;  // present the upper nibble again
    logic loadLow;   // present the lower nibble
    logic raiseE;
    logic dropE;
  } wrStrobes_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_TAIL
  } wrPhase_t;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int nsToCycles(real clkHz, int ns);
    int c;
    c = int'($ceil(real'(ns) * clkHz / 1.0e9));
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/lcd_wr_datapath.sv
module lcd_wr_datapath
  import lcd_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  wrStrobes_t stb,
  input  logic [7:0] inByte,
  input  logic       inRs,
  output logic       lcdE,
  output logic       lcdRs,
  output logic [7:0] lcdDq
);

  logic [7:0] byteQ;
  logic [3:0] nibQ;
  logic       rsQ;
  logic       eQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      byteQ <= '0;
      nibQ  <= '0;
      rsQ   <= 1'b0;
      eQ    <= 1'b0;
    end else begin
      if (stb.capture) begin
        byteQ <= inByte;
        rsQ   <= inRs;
        nibQ  <= inByte[7:4];
      end else if (stb.loadHigh) begin
        nibQ  <= byteQ[7:4];
      end else if (stb.loadLow) begin
        nibQ  <= byteQ[3:0];
      end

      if (stb.raiseE)     eQ <= 1'b1;
      else if (stb.dropE) eQ <= 1'b0;
    end
  end

  assign lcdE  = eQ;
  assign lcdRs = rsQ;
  assign lcdDq = {nibQ, 4'b0000};

endmodule

// File: rtl/lcd_wr_ctrl.sv
module lcd_wr_ctrl
  import lcd_wr_pkg::*;
#(
  parameter int SETUP_CYC = 5,
  parameter int PULSE_CYC = 32,
  parameter int TAIL_CYC  = 31
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       wrFnSet,
  output wrStrobes_t stb,
  output logic       done
);

  localparam int MAX_SP  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_CYC = (MAX_SP > TAIL_CYC) ? MAX_SP : TAIL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] TAIL_LD  = CNT_W'(TAIL_CYC - 1);

  wrPhase_t         phase;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       idx;
  logic [1:0]       lastIdx;
  logic             doneQ;

  logic       cntZero;
  logic       lastNib;
  logic [1:0] nextIdx;

  assign cntZero = (cnt == '0);
  assign lastNib = (idx == lastIdx);
  assign nextIdx = idx + 2'd1;

  always_comb begin
    stb = '0;
    unique case (phase)
      PH_IDLE:   stb.capture = wrEn;
      PH_SETUP:  stb.raiseE  = cntZero;
      PH_STROBE: stb.dropE   = cntZero;
      PH_TAIL: begin
        if (cntZero && !lastNib) begin
          if (nextIdx == lastIdx) stb.loadLow  = 1'b1;
          else                    stb.loadHigh = 1'b1;
        end
      end
      default: stb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      idx     <= '0;
      lastIdx <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (wrEn) begin
            phase   <= PH_SETUP;
            cnt     <= SETUP_LD;
            idx     <= 2'd0;
            lastIdx <= wrFnSet ? 2'd2 : 2'd1;
          end
        end
        PH_SETUP: begin
          if (cntZero) begin
            phase <= PH_STROBE;
            cnt   <= PULSE_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cntZero) begin
            phase <= PH_TAIL;
            cnt   <= TAIL_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_TAIL: begin
          if (cntZero) begin
            if (lastNib) begin
              phase <= PH_IDLE;
              doneQ <= 1'b1;
            end else begin
              phase <= PH_SETUP;
              cnt   <= SETUP_LD;
              idx   <= nextIdx;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign done = doneQ;

endmodule

// File: rtl/lcd_nibble_writer.sv
module lcd_nibble_writer
  import lcd_wr_pkg::*;
#(
  parameter real CLK_FREQ_HZ = 125.0e6,
  parameter int  T_SETUP_NS  = 40,
  parameter int  T_PULSE_NS  = 250,
  parameter int  T_CYCLE_NS  = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic [7:0] wrByte,
  input  logic       wrRs,
  input  logic       wrFnSet,
  output logic       done,
  output logic       lcdE,
  output logic       lcdRs,
  output logic [7:0] lcdDq
);

  localparam int SETUP_CYC = nsToCycles(CLK_FREQ_HZ, T_SETUP_NS);
  localparam int PULSE_CYC = nsToCycles(CLK_FREQ_HZ, T_PULSE_NS);
  localparam int CYCLE_CYC = nsToCycles(CLK_FREQ_HZ, T_CYCLE_NS);
  localparam int TAIL_CYC  = (CYCLE_CYC > PULSE_CYC) ? (CYCLE_CYC - PULSE_CYC) : 1;

  wrStrobes_t stb;

  lcd_wr_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .TAIL_CYC  (TAIL_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrFnSet (wrFnSet),
    .stb     (stb),
    .done    (done)
  );

  lcd_wr_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .inByte (wrByte),
    .inRs   (wrRs),
    .lcdE   (lcdE),
    .lcdRs  (lcdRs),
    .lcdDq  (lcdDq)
  );

endmodule

// File: rtl/lcd_nibble_writer_chk.sv
module lcd_nibble_writer_chk
  import lcd_wr_pkg::*;
#(
  parameter real CLK_FREQ_HZ = 125.0e6,
  parameter int  T_SETUP_NS  = 40,
  parameter int  T_PULSE_NS  = 250,
  parameter int  T_CYCLE_NS  = 500
) (
  input logic       clk,
  input logic       rst,
  input logic       done,
  input logic       lcdE,
  input logic       lcdRs,
  input logic [7:0] lcdDq
);

  localparam int SETUP_CYC = nsToCycles(CLK_FREQ_HZ, T_SETUP_NS);
  localparam int PULSE_CYC = nsToCycles(CLK_FREQ_HZ, T_PULSE_NS);
  localparam int CYCLE_CYC = nsToCycles(CLK_FREQ_HZ, T_CYCLE_NS);

  logic       ePrev;
  logic       rsPrev;
  logic [7:0] dqPrev;
  int         runLen;     // consecutive low-enable samples with unchanged bus
  int         highLen;    // samples of the current high pulse
  int         sinceRise;  // samples since the last rise, saturating

  logic riseNow;
  logic fallNow;
  assign riseNow = lcdE && !ePrev;
  assign fallNow = !lcdE && ePrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ePrev     <= 1'b0;
      rsPrev    <= 1'b0;
      dqPrev    <= '0;
      runLen    <= 0;
      highLen   <= 0;
      sinceRise <= CYCLE_CYC;
    end else begin
      ePrev  <= lcdE;
      rsPrev <= lcdRs;
      dqPrev <= lcdDq;
      if (!lcdE) begin
        if (lcdDq == dqPrev && lcdRs == rsPrev) runLen <= runLen + 1;
        else                                    runLen <= 1;
      end
      highLen <= lcdE ? highLen + 1 : 0;
      if (riseNow)                    sinceRise <= 1;
      else if (sinceRise < CYCLE_CYC) sinceRise <= sinceRise + 1;
    end
  end

  assert_bus_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (lcdE && $past(lcdE)) |-> ($stable(lcdDq) && $stable(lcdRs)));

  assert_setup_run_R3: assert property (@(posedge clk) disable iff (rst)
    riseNow |-> (runLen >= SETUP_CYC));

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
    fallNow |-> (highLen >= PULSE_CYC));

  assert_rise_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    riseNow |-> (sinceRise >= CYCLE_CYC));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_enable_low_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !lcdE);

endmodule

bind lcd_nibble_writer lcd_nibble_writer_chk #(
  .CLK_FREQ_HZ (CLK_FREQ_HZ),
  .T_SETUP_NS  (T_SETUP_NS),
  .T_PULSE_NS  (T_PULSE_NS),
  .T_CYCLE_NS  (T_CYCLE_NS)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .done  (done),
  .lcdE  (lcdE),
  .lcdRs (lcdRs),
  .lcdDq (lcdDq)
);

// File: tb/lcd_nibble_writer_tb.sv
`timescale 1ns/1ps
module lcd_nibble_writer_tb;

  // Cycle counts from the requirements at 125 MHz, rounded up with integer math.
  localparam int SETUP_N = (40 * 125 + 999) / 1000;   // 5
  localparam int PULSE_N = (250 * 125 + 999) / 1000;  // 32
  localparam int CYCLE_N = (500 * 125 + 999) / 1000;  // 63
  localparam int TAIL_N  = CYCLE_N - PULSE_N;         // 31

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrByte = '0;
  logic       wrRs = 1'b0;
  logic       wrFnSet = 1'b0;
  logic       done;
  logic       lcdE;
  logic       lcdRs;
  logic [7:0] lcdDq;

  always #4 clk = ~clk;

  lcd_nibble_writer u_dut (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrByte  (wrByte),
    .wrRs    (wrRs),
    .wrFnSet (wrFnSet),
    .done    (done),
    .lcdE    (lcdE),
    .lcdRs   (lcdRs),
    .lcdDq   (lcdDq)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: per-cycle expected {done, e, rs, dq[7:0]}.
  logic [10:0] expQ[$];
  int          expStrobes[$];
  logic        holdRs = 1'b0;
  logic [7:0]  holdDq = '0;
  logic        comparing = 1'b0;
  int          doneCount = 0;
  int          riseCount = 0;
  logic        eLast = 1'b0;

  task automatic pushNibble(logic rs, logic [3:0] nib);
    for (int i = 0; i < SETUP_N; i++) expQ.push_back({1'b0, 1'b0, rs, nib, 4'h0});
    for (int i = 0; i < PULSE_N; i++) expQ.push_back({1'b0, 1'b1, rs, nib, 4'h0});
    for (int i = 0; i < TAIL_N;  i++) expQ.push_back({1'b0, 1'b0, rs, nib, 4'h0});
  endtask

  always @(posedge clk) begin
    if (rst) begin
      expQ.delete();
    end else if (wrEn && expQ.size() == 0) begin
      pushNibble(wrRs, wrByte[7:4]);
      if (wrFnSet) pushNibble(wrRs, wrByte[7:4]);
      pushNibble(wrRs, wrByte[3:0]);
      expQ.push_back({1'b1, 1'b0, wrRs, wrByte[3:0], 4'h0});
      expStrobes.push_back(wrFnSet ? 3 : 2);
    end
  end

  always @(negedge clk) begin
    logic [10:0] e;
    if (comparing) begin
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        holdRs = e[8];
        holdDq = e[7:0];
      end else begin
        e = {2'b00, holdRs, holdDq};
      end
      check("R8", "done", int'(done), int'(e[10]));
      check("R3/R4/R5", "lcdE", int'(lcdE), int'(e[9]));
      check("R2", "lcdRs", int'(lcdRs), int'(e[8]));
      check("R6/R7", "lcdDq", int'(lcdDq), int'(e[7:0]));
      if (lcdE && !eLast) riseCount++;
      eLast = lcdE;
      if (done) begin
        doneCount++;
        if (expStrobes.size() > 0) check("R6/R7", "strobes per transfer", riseCount, expStrobes.pop_front());
        else check("R9", "unexpected transfer", 1, 0);
        riseCount = 0;
      end
    end
  end

  task automatic send(logic [7:0] b, logic rs, logic fn);
    wrByte = b; wrRs = rs; wrFnSet = fn; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrFnSet = 1'b0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!done);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles >= 50000) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog: actual no finish, expected finish before %0d cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "lcdE in reset", int'(lcdE), 0);
    check("R1", "lcdRs in reset", int'(lcdRs), 0);
    check("R1", "lcdDq in reset", int'(lcdDq), 0);
    check("R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    comparing = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "lcdDq idle after reset", int'(lcdDq), 0);

    // R6, R2: character data, normal two-strobe transfer
    send(8'h41, 1'b1, 1'b0);
    waitDone();
    @(negedge clk);

    // R7: mode-switch instruction, with R9 request injected mid-transfer
    send(8'h28, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    send(8'hFF, 1'b1, 1'b0);
    repeat (90) @(negedge clk);
    send(8'h5A, 1'b1, 1'b1);
    waitDone();
    @(negedge clk);

    // R8: request accepted in the done cycle (back-to-back)
    send(8'h01, 1'b0, 1'b0);
    waitDone();
    send(8'hA5, 1'b1, 1'b1);
    waitDone();

    // R6: equal nibbles and all-ones data
    @(negedge clk);
    send(8'hFF, 1'b1, 1'b0);
    waitDone();
    @(negedge clk);
    send(8'h3C, 1'b0, 1'b0);
    waitDone();
    repeat (20) @(negedge clk);

    check("R9", "completed transfers", doneCount, 6);
    check("R9", "pending model entries", expQ.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule